// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix Array

This block multiplies a stream of integer activation vectors by a square weight matrix that is held inside the array. It is built from N×N identical multiply-accumulate cells. A weight is shifted into each cell before any computation starts. Each cell then multiplies its fixed weight by the activation passing through it. It adds that product to the partial sum coming down from the cell above, hands the activation to its right-hand neighbour and hands the new sum to the cell below. Partial sums move only between adjacent cells. No intermediate value leaves the grid.

The caller loads weights through a column-parallel shift port, one matrix row per cycle, for exactly N cycles. It then presents one unskewed activation vector per cycle with a valid strobe. The block delays row r's activation by r cycles at the left edge. It delays column c's bottom result by N-1-c cycles, so each output vector comes out aligned under a single valid flag. Activations and weights are 8-bit two's complement values. Sums are 32-bit two's complement values. With the default N=4, a new vector may be accepted every cycle.

Top module: `systolic_mm_array`

## Requirements
- R1: A synchronous active-low reset clears every weight, every partial sum and the valid pipeline. res_valid is 0 in the cycle after reset is released. A vector sent before any weight load yields an all-zero result, and so does a vector sent after a reset taken in the middle of a stream.
- R2: While wt_load is high, each clock shifts the weights one row down in every column. Column c takes wt_in[c*8 +: 8] into row 0. After N load cycles, the value presented on load step j (j = 0 first) sits in row N-1-j.
- R3: Row r of an input vector is act_in[r*8 +: 8]. Column c of the result is res_out[c*32 +: 32] and equals the sum over r of act[r]·W[r][c], with signed operands and a signed 32-bit sum.
- R4: A vector presented with act_valid high in cycle k appears on res_out with res_valid high in cycle k+2N-1. Every accepted vector produces exactly one result.
- R5: Vectors sent on consecutive cycles produce results on consecutive cycles, in order, with no interference between them.
- R6: While wt_load is low, the stored weights do not change, whatever wt_in carries.
- R7: res_valid is high only in the cycles fixed by R4. Idle cycles (bubbles) between inputs produce matching gaps in the output and do not alter neighbouring results.
- R8: Extreme operands are exact. Weights and activations all at -128 give 65536 per column. Weights at -128 with activations at 127 give -65024.
- R9: A second full load completely replaces the previous matrix. Later results use only the new weights.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wt_load | input | 1 | Shift wt_in into the top row and move every column's weights down one row |
| wt_in | input | N*8 | One weight per column, column c at bits [c*8 +: 8] |
| act_valid | input | 1 | act_in holds a vector to process this cycle |
| act_in | input | N*8 | Unskewed activation vector, row r at bits [r*8 +: 8] |
| res_valid | output | 1 | res_out holds an aligned result vector |
| res_out | output | N*32 | Result vector, column c at bits [c*32 +: 32] |

## Verification
The checks assume that the caller never raises wt_load while a vector is being accepted or while any result is still inside the array. They also assume that every result has been drained before a reload starts. The checker keeps a count of vectors in flight. From that count it flags loads that overlap computation, results that appear with nothing in flight, and more vectors in flight than the pipeline depth allows. The bench always idles for longer than 2N-1 cycles before each load. It holds act_valid low throughout a load. It also drives random values on wt_in while wt_load is low, which exercises weight holding without breaking the load rule.

// File: rtl/sa_pkg.sv
// Package: default geometry and operand widths shared by the systolic array
// and its checker. Every module takes these as parameter defaults.
package sa_pkg;
    localparam int unsigned SA_DIM   = 4;   // rows = columns of the grid
    localparam int unsigned SA_ACT_W = 8;   // activation width (signed)
    localparam int unsigned SA_WGT_W = 8;   // weight width (signed)
    localparam int unsigned SA_SUM_W = 32;  // partial-sum width (signed)
endpackage

// File: rtl/sa_delay.sv
// Module: sa_delay
// A fixed-length register pipeline, used for input skew, output de-skew and
// the valid strobe. Assumes DEPTH >= 1. The caller bypasses zero-depth cases.
module sa_delay #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [DEPTH];

    // Shift one stage per clock; reset clears all stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < int'(DEPTH); i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign dout = stage_q[DEPTH-1];
endmodule

// File: rtl/sa_pe.sv
// Module: sa_pe
// One multiply-accumulate cell. It multiplies the activation passing through
// by the weight held for it and adds the product to the sum from above,
// registering the result for the cell below. Assumes SUM_W >= ACT_W + WGT_W.
module sa_pe #(
    parameter int unsigned ACT_W = 8,
    parameter int unsigned WGT_W = 8,
    parameter int unsigned SUM_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [ACT_W-1:0] act_in,
    input  logic signed [WGT_W-1:0] wgt,
    input  logic signed [SUM_W-1:0] psum_in,
    output logic signed [SUM_W-1:0] psum_out
);
    localparam int unsigned PROD_W = ACT_W + WGT_W;

    logic signed [PROD_W-1:0] prod;
    logic signed [SUM_W-1:0]  psum_q;

    // Full-precision signed product.
    assign prod = act_in * wgt;

    // Accumulate into the registered partial sum.
    always_ff @(posedge clk) begin
        if (!rst_n) psum_q <= '0;
        else        psum_q <= psum_in + SUM_W'(prod);
    end

    assign psum_out = psum_q;
endmodule

// File: rtl/systolic_mm_array.sv
// Module: systolic_mm_array
// N x N weight-stationary systolic grid. Weights shift down the columns while
// wt_load is high and hold otherwise. Activations are skewed by row index,
// travel right one cell per cycle and meet partial sums that start at zero
// on the top row and move down one cell per cycle. Bottom-row sums are
// de-skewed so that a full result vector leaves together 2N-1 cycles after
// its input. Assumes that no load overlaps a vector in flight.
module systolic_mm_array
    import sa_pkg::*;
#(
    parameter int unsigned N     = SA_DIM,
    parameter int unsigned ACT_W = SA_ACT_W,
    parameter int unsigned WGT_W = SA_WGT_W,
    parameter int unsigned SUM_W = SA_SUM_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wt_load,
    input  logic [N*WGT_W-1:0] wt_in,
    input  logic               act_valid,
    input  logic [N*ACT_W-1:0] act_in,
    output logic               res_valid,
    output logic [N*SUM_W-1:0] res_out
);
    localparam int unsigned LATENCY = 2*N - 1;

    logic signed [ACT_W-1:0] act_h  [N][N];    // activation entering cell (r,c)
    logic signed [WGT_W-1:0] wgt_v  [N][N];    // weight held in cell (r,c)
    logic signed [SUM_W-1:0] psum_v [N+1][N];  // sum entering row r of column c

    genvar r, c;
    generate
        for (r = 0; r < N; r++) begin : g_row
            // Left-edge skew: row r waits r cycles.
            if (r == 0) begin : g_noskew
                assign act_h[r][0] = act_in[ACT_W-1:0];
            end else begin : g_skew
                sa_delay #(.WIDTH(ACT_W), .DEPTH(r)) u_skew (
                    .clk  (clk),
                    .rst_n(rst_n),
                    .din  (act_in[r*ACT_W +: ACT_W]),
                    .dout (act_h[r][0])
                );
            end

            for (c = 0; c < N; c++) begin : g_col
                logic signed [WGT_W-1:0] wgt_q;

                // Weight holder: shift from above during load, hold otherwise.
                if (r == 0) begin : g_wtop
                    always_ff @(posedge clk) begin
                        if (!rst_n)       wgt_q <= '0;
                        else if (wt_load) wgt_q <= wt_in[c*WGT_W +: WGT_W];
                    end
                end else begin : g_wmid
                    always_ff @(posedge clk) begin
                        if (!rst_n)       wgt_q <= '0;
                        else if (wt_load) wgt_q <= wgt_v[r-1][c];
                    end
                end
                assign wgt_v[r][c] = wgt_q;

                // Activation hand-off to the right neighbour.
                if (c < N-1) begin : g_fwd
                    logic signed [ACT_W-1:0] fwd_q;
                    always_ff @(posedge clk) begin
                        if (!rst_n) fwd_q <= '0;
                        else        fwd_q <= act_h[r][c];
                    end
                    assign act_h[r][c+1] = fwd_q;
                end

                sa_pe #(.ACT_W(ACT_W), .WGT_W(WGT_W), .SUM_W(SUM_W)) u_pe (
                    .clk     (clk),
                    .rst_n   (rst_n),
                    .act_in  (act_h[r][c]),
                    .wgt     (wgt_v[r][c]),
                    .psum_in (psum_v[r][c]),
                    .psum_out(psum_v[r+1][c])
                );
            end
        end

        for (c = 0; c < N; c++) begin : g_out
            // Top row starts every column from zero.
            assign psum_v[0][c] = '0;

            // Bottom-edge de-skew: column c waits N-1-c cycles.
            if (c == N-1) begin : g_nodeskew
                assign res_out[c*SUM_W +: SUM_W] = psum_v[N][c];
            end else begin : g_deskew
                sa_delay #(.WIDTH(SUM_W), .DEPTH(N-1-c)) u_deskew (
                    .clk  (clk),
                    .rst_n(rst_n),
                    .din  (psum_v[N][c]),
                    .dout (res_out[c*SUM_W +: SUM_W])
                );
            end
        end
    endgenerate

    // Valid strobe travels alongside the data through the whole pipeline.
    sa_delay #(.WIDTH(1), .DEPTH(LATENCY)) u_vpipe (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (act_valid),
        .dout (res_valid)
    );
endmodule

// File: rtl/systolic_mm_array_checker.sv
// Module: systolic_mm_array_checker
// Port-level checks for the systolic array. It keeps its own count of vectors
// in flight (accepted but not yet returned) and relates it to loads and
// results. Assumes that the caller drains the array before each load.
module systolic_mm_array_checker #(
    parameter int unsigned N     = 4,
    parameter int unsigned SUM_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wt_load,
    input logic               act_valid,
    input logic               res_valid,
    input logic [N*SUM_W-1:0] res_out
);
    localparam int unsigned CNT_W = $clog2(2*N + 2) + 1;

    logic [CNT_W-1:0] inflight_q;

    // Track vectors accepted minus results delivered.
    always_ff @(posedge clk) begin
        if (!rst_n) inflight_q <= '0;
        else        inflight_q <= inflight_q + CNT_W'(act_valid) - CNT_W'(res_valid);
    end

    // R1: nothing valid straight after reset release.
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !res_valid);

    // R2: loading only when the array holds no work.
    assert_load_isolated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wt_load |-> (!act_valid && inflight_q == '0));

    // R3: a presented result is fully defined.
    assert_result_known_R3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !$isunknown(res_out));

    // R4: no vector stays longer than the pipeline depth.
    assert_inflight_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        inflight_q <= CNT_W'(2*N - 1));

    // R7: a result only appears when something was accepted.
    assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> inflight_q != '0);
endmodule

bind systolic_mm_array systolic_mm_array_checker #(.N(N), .SUM_W(SUM_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wt_load  (wt_load),
    .act_valid(act_valid),
    .res_valid(res_valid),
    .res_out  (res_out)
);

// File: tb/systolic_mm_array_bench.sv
module systolic_mm_array_bench;
    localparam int N   = 4;
    localparam int AW  = 8;
    localparam int WW  = 8;
    localparam int SW  = 32;
    localparam int LAT = 2*N - 1;
    localparam int NT  = 8;
    localparam logic [N*AW-1:0] STIM [NT] = '{
        32'h01020304, 32'hFFFEFDFC, 32'h7F80017F, 32'h00000000,
        32'h10F00AF6, 32'h05050505, 32'h80808080, 32'h3CC419E7 };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wt_load = 1'b0;
    logic [N*WW-1:0] wt_in = '0;
    logic act_valid = 1'b0;
    logic [N*AW-1:0] act_in = '0;
    logic res_valid;
    logic [N*SW-1:0] res_out;

    int nchk = 0, nbad = 0, cyc = 0;
    bit done = 0;
    logic signed [WW-1:0] wm [N][N];
    logic [N*SW-1:0] exp_val [64];
    int exp_cyc [64];
    string exp_tag [64];
    int wr = 0, rd = 0;

    systolic_mm_array u_systolic_mm_array (
        .clk(clk), .rst_n(rst_n), .wt_load(wt_load), .wt_in(wt_in),
        .act_valid(act_valid), .act_in(act_in),
        .res_valid(res_valid), .res_out(res_out));

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Reference: result column c = sum_r act[r] * W[r][c].
    function automatic logic [N*SW-1:0] model(input logic [N*AW-1:0] x);
        logic [N*SW-1:0] v;
        for (int c = 0; c < N; c++) begin
            logic signed [SW-1:0] acc = '0;
            for (int r = 0; r < N; r++)
                acc = acc + $signed(x[r*AW +: AW]) * wm[r][c];
            v[c*SW +: SW] = acc;
        end
        return v;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] expv);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic send(input logic [N*AW-1:0] x, input string tag);
        @(negedge clk);
        act_valid = 1'b1; act_in = x;
        exp_val[wr % 64] = model(x); exp_cyc[wr % 64] = cyc + LAT; exp_tag[wr % 64] = tag;
        wr++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            act_valid = 1'b0; act_in = $urandom; wt_in = $urandom;
        end
    endtask

    // Push matrix rows bottom-first so row N-1-j lands from step j (R2).
    task automatic load_matrix();
        for (int j = 0; j < N; j++) begin
            @(negedge clk);
            wt_load = 1'b1;
            for (int c = 0; c < N; c++) wt_in[c*WW +: WW] = wm[N-1-j][c];
        end
        @(negedge clk);
        wt_load = 1'b0;
    endtask

    // Result monitor: value (R3/R5...) and arrival cycle (R4).
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (rd == wr) begin
                check(1'b0, "R7 unexpected res_valid", 128'(res_valid), 128'(0));
            end else begin
                check(res_out == exp_val[rd % 64], exp_tag[rd % 64], res_out, exp_val[rd % 64]);
                check(cyc == exp_cyc[rd % 64], "R4 arrival cycle", 128'(cyc), 128'(exp_cyc[rd % 64]));
                rd++;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) wm[r][c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(res_valid == 1'b0, "R1 valid after reset", 128'(res_valid), 128'(0));
        send(32'h11223344, "R1 zero weights");
        idle(LAT + 3);

        // Main table with an asymmetric matrix (R3, R5 back-to-back).
        for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) wm[r][c] = WW'(r*N + c - 6);
        load_matrix();
        for (int i = 0; i < NT; i++) send(STIM[i], "R3 R5 table");
        idle(LAT + 3);

        // R2 placement: only row 2 nonzero.
        for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) wm[r][c] = (r == 2) ? WW'(c + 1) : '0;
        load_matrix();
        send(32'h09050909, "R2 row placement");
        idle(LAT + 3);

        // R7 bubbles between inputs.
        send(STIM[0], "R7 bubble");
        idle(2);
        send(STIM[4], "R7 bubble");
        idle(1);
        send(STIM[7], "R7 bubble");
        idle(LAT + 3);

        // R6 hold: long idle with random wt_in, load low.
        idle(20);
        send(STIM[4], "R6 weights hold");
        idle(LAT + 3);

        // R8 extremes.
        for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) wm[r][c] = 8'sh80;
        load_matrix();
        send(32'h80808080, "R8 min*min");
        send(32'h7F7F7F7F, "R8 max*min");
        idle(LAT + 3);
        check(model(32'h80808080) == {4{32'd65536}}, "R8 model min", model(32'h80808080), {4{32'd65536}});

        // R9 reload with a permutation matrix.
        for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) wm[r][c] = (c == (r + 1) % N) ? 8'sd1 : 8'sd0;
        load_matrix();
        send(32'h0A0B0C0D, "R9 reload");
        send(STIM[2], "R9 reload");
        idle(LAT + 3);

        // R1 reset in the middle of a stream.
        send(STIM[0], "R1 flushed");
        send(STIM[1], "R1 flushed");
        send(STIM[2], "R1 flushed");
        @(negedge clk);
        act_valid = 1'b0; rst_n = 1'b0;
        rd = wr;
        @(negedge clk);
        check(res_valid == 1'b0, "R1 valid in reset", 128'(res_valid), 128'(0));
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(res_valid == 1'b0, "R1 valid after midstream reset", 128'(res_valid), 128'(0));
        idle(LAT + 3);
        for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) wm[r][c] = '0;
        send(STIM[5], "R1 weights cleared");
        idle(LAT + 3);

        check(rd == wr, "R4 all results delivered", 128'(rd), 128'(wr));
        done = 1;
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule